// File: doc/BRIEF.md
# Interrupt Aggregation and Status Controller

This block collects ten interrupt sources into one host interrupt line. Four of the sources are the summary lines of four GPIO banks, and six are request lines from other peripherals. Each source is captured into a status register, and the host reads that register through a small 16-bit register port. An enable register holds one enable bit for each source and one global enable bit. The single output is raised when at least one enabled source is pending and the global enable is set.

The host treats the output as rising-edge triggered. Its service routine reads the status register, handles the sources it finds, and repeats until status reads zero. After each status read, any source that is still pending must produce a new rising edge. To do this, a read of status while the output is high drops the output for exactly one cycle, and the output rises again if a pending source remains.

The output comes from a three-state machine:
- Idle: output low.
- Fire: output high.
- Rearm: output forced low for one cycle.

The transitions are:
- Idle to Fire when an enabled source is pending.
- Fire to Idle when no enabled source is pending.
- Fire to Rearm on a status read.
- Rearm to Fire when a source is still pending.
- Rearm to Idle when nothing is pending.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable register reads 0x0000, the output is low and status reads 0 while all sources are low.
- R2: Register select 0 reads status. Status bits 3..0 show the four bank summary lines as sampled at the previous clock edge, and a bit clears when its line is cleared.
- R3: Status bits 9..4 show peripheral requests 0..5 in ascending order, one cycle after the request changes. Status bits 15..10 read zero.
- R4: Register select 1 is the enable register. Bits 9..0 are the per-source enables, with 1 meaning enabled, and bit 15 is the global enable. A write stores those eleven bits, and bits 14..10 read zero.
- R5: When the global enable is 1 and a source whose enable bit is 1 becomes pending, the output is high from the second clock edge after the input or the enable write is presented.
- R6: A pending source whose enable bit is 0 never raises the output.
- R7: With the global enable at 0, the output stays low whatever the status and per-source enables are.
- R8: A status read presented while the output is high drives the output low at the next edge. If an enabled source is still pending, the output goes high again one edge later.
- R9: A status read while the output is low has no effect on the output.
- R10: The output falls at the second edge after the last enabled pending source is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sum_i | input | 4 | Summary interrupt lines of GPIO banks A..D |
| periph_req_i | input | 6 | Peripheral interrupt requests 0..5 |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wr_i | input | 1 | Write strobe; writes the enable register when reg_sel_i is 1 |
| reg_rd_i | input | 1 | Read strobe; a status read re-arms the edge |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Interrupt output to the host |

## Verification
Status is registered once, so a source change is due on the read port one cycle after it is presented. The output passes through the status flop and the state flop, so it is due two cycles after a source change or an enable write. A status read acts at the next edge, so the one-cycle low is due one cycle after the read and the new rise one cycle after that. The bench driver stores each expectation with the exact cycle number it is due. A monitor at the falling clock edge compares only the items whose cycle has come, so no result is sampled before its register chain has settled.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRE  = 2'd1,
        ST_REARM = 2'd2
    } irq_state_e;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_ENABLE = 1'b1;

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
    parameter int N_BANK   = 4,
    parameter int N_PERIPH = 6,
    localparam int N_SRC   = N_BANK + N_PERIPH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_BANK-1:0]   bank_sum_i,
    input  logic [N_PERIPH-1:0] periph_req_i,
    output logic [N_SRC-1:0]    stat_o
);

    logic [N_SRC-1:0] raw;

    // Banks occupy the low bits, peripherals follow in ascending order (R2, R3)
    assign raw = {periph_req_i, bank_sum_i};

    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_o[g] <= 1'b0;
            else        stat_o[g] <= raw[g];
        end
    end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int N_SRC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [N_SRC-1:0] src_wdata_i,
    input  logic             glob_wdata_i,
    output logic [N_SRC-1:0] src_en_o,
    output logic             glob_en_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_en_o  <= '0;
            glob_en_o <= 1'b0;
        end else if (wr_i) begin
            src_en_o  <= src_wdata_i;
            glob_en_o <= glob_wdata_i;
        end
    end

endmodule

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_agg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       stat_rd_i,
    output logic       irq_o,
    output irq_state_e state_o
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (active_i) state_d = ST_FIRE;
            ST_FIRE: begin
                if (!active_i)      state_d = ST_IDLE;
                else if (stat_rd_i) state_d = ST_REARM;
            end
            ST_REARM: state_d = active_i ? ST_FIRE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o   = (state_q == ST_FIRE);
        state_o = state_q;
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N_BANK   = 4,
    parameter int N_PERIPH = 6,
    parameter int DATA_W   = 16,
    parameter int GEN_BIT  = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_BANK-1:0]   bank_sum_i,
    input  logic [N_PERIPH-1:0] periph_req_i,
    input  logic                reg_sel_i,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                irq_o
);

    localparam int N_SRC = N_BANK + N_PERIPH;

    logic [N_SRC-1:0] src_stat;
    logic [N_SRC-1:0] src_en;
    logic             glob_en;
    logic             active;
    logic             stat_rd;
    irq_state_e       fsm_state;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata_i;

    irq_src_capture #(.N_BANK(N_BANK), .N_PERIPH(N_PERIPH)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_sum_i   (bank_sum_i),
        .periph_req_i (periph_req_i),
        .stat_o       (src_stat)
    );

    irq_enable_reg #(.N_SRC(N_SRC)) u_en (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr_i && (reg_sel_i == SEL_ENABLE)),
        .src_wdata_i  (reg_wdata_i[N_SRC-1:0]),
        .glob_wdata_i (reg_wdata_i[GEN_BIT]),
        .src_en_o     (src_en),
        .glob_en_o    (glob_en)
    );

    assign active  = glob_en && (|(src_stat & src_en));
    assign stat_rd = reg_rd_i && (reg_sel_i == SEL_STATUS);

    irq_edge_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .stat_rd_i (stat_rd),
        .irq_o     (irq_o),
        .state_o   (fsm_state)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_sel_i == SEL_ENABLE) begin
            reg_rdata_o[N_SRC-1:0] = src_en;
            reg_rdata_o[GEN_BIT]   = glob_en;
        end else begin
            reg_rdata_o[N_SRC-1:0] = src_stat;
        end
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int N_BANK   = 4,
    parameter int N_PERIPH = 6,
    localparam int N_SRC   = N_BANK + N_PERIPH
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_BANK-1:0]   bank_sum_i,
    input logic [N_PERIPH-1:0] periph_req_i,
    input logic                reg_sel_i,
    input logic                reg_rd_i,
    input logic [N_SRC-1:0]    src_stat,
    input logic [N_SRC-1:0]    src_en,
    input logic                glob_en,
    input logic                irq_o
);

    logic want;
    assign want = glob_en && ((src_stat & src_en) != '0);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !glob_en && src_en == '0));

    a_r2_bank_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> src_stat[N_BANK-1:0] == $past(bank_sum_i));

    a_r3_periph_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> src_stat[N_SRC-1:N_BANK] == $past(periph_req_i));

    a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (want && !irq_o) |=> irq_o);

    a_r7_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !irq_o);

    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_stat & src_en) == '0) |=> !irq_o);

    a_r8_rearm_low: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && reg_rd_i && !reg_sel_i) |=> !irq_o);

endmodule

bind irq_aggregator irq_aggregator_chk #(.N_BANK(N_BANK), .N_PERIPH(N_PERIPH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank_sum_i   (bank_sum_i),
    .periph_req_i (periph_req_i),
    .reg_sel_i    (reg_sel_i),
    .reg_rd_i     (reg_rd_i),
    .src_stat     (src_stat),
    .src_en       (src_en),
    .glob_en      (glob_en),
    .irq_o        (irq_o)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

    typedef struct {
        int          due;
        bit          is_reg;
        logic [15:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank_sum = '0;
    logic [5:0]  periph = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_aggregator u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_sum_i   (bank_sum),
        .periph_req_i (periph),
        .reg_sel_i    (reg_sel),
        .reg_wr_i     (reg_wr),
        .reg_rd_i     (reg_rd),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .irq_o        (irq)
    );

    // Monitor: compare every expectation whose cycle has come
    always @(negedge clk) begin
        int i;
        logic [15:0] got;
        i = 0;
        while (i < q.size()) begin
            if (q[i].due <= cyc) begin
                got = q[i].is_reg ? reg_rdata : {15'd0, irq};
                n_chk++;
                if (got !== q[i].exp) begin
                    n_err++;
                    $display("FAIL %s cycle %0d %s: got %h expected %h", q[i].tag, cyc,
                             q[i].is_reg ? "rdata" : "irq", got, q[i].exp);
                end
                q.delete(i);
            end else begin
                i++;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 20000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic want(int due, bit is_reg, logic [15:0] exp, string tag);
        exp_t e;
        e.due = due; e.is_reg = is_reg; e.exp = exp; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr_en_reg(logic [15:0] v);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(logic sel, logic [15:0] exp, string tag);
        reg_sel = sel; reg_rd = 1'b1;
        want(cyc, 1'b1, exp, tag);
        step();
        reg_rd = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) step();
    endtask

    initial begin
        int c;
        steps(3);
        rst_n = 1'b1;
        step();

        // R1: reset values
        rd_check(1'b0, 16'h0000, "R1");
        want(cyc, 1'b0, 16'h0000, "R1");
        rd_check(1'b1, 16'h0000, "R1");

        // R4: enable register layout, reserved bits read zero
        wr_en_reg(16'hFFFF);
        rd_check(1'b1, 16'h83FF, "R4");
        wr_en_reg(16'h0000);
        rd_check(1'b1, 16'h0000, "R4");

        // R7: global enable off blocks everything
        wr_en_reg(16'h03FF);
        bank_sum = 4'b0010;
        c = cyc;
        want(c + 2, 1'b0, 16'h0000, "R7");
        want(c + 3, 1'b0, 16'h0000, "R7");
        steps(3);
        rd_check(1'b0, 16'h0002, "R2");

        // R6: pending source with enable bit 0
        wr_en_reg(16'h8001);
        want(cyc + 1, 1'b0, 16'h0000, "R6");
        want(cyc + 2, 1'b0, 16'h0000, "R6");
        steps(3);

        // R5: enabling the pending source raises the output two edges after the write
        wr_en_reg(16'h8002);
        want(cyc, 1'b0, 16'h0000, "R5");
        want(cyc + 1, 1'b0 == 1'b0 ? 1'b0 : 1'b0, 16'h0001, "R5");
        steps(2);

        // R8: status read while high: one low cycle, then high again
        want(cyc, 1'b0, 16'h0001, "R8");
        rd_check(1'b0, 16'h0002, "R8");
        want(cyc, 1'b0, 16'h0000, "R8");
        want(cyc + 1, 1'b0, 16'h0001, "R8");
        steps(2);

        // R10: clearing the last enabled source drops the output
        bank_sum = 4'b0000;
        c = cyc;
        want(c + 1, 1'b0, 16'h0001, "R10");
        want(c + 2, 1'b0, 16'h0000, "R10");
        steps(3);
        rd_check(1'b0, 16'h0000, "R2");

        // R3: peripheral bits in ascending order from bit 4
        wr_en_reg(16'h83F0);
        for (int i = 0; i < 6; i++) begin
            periph = 6'(1 << i);
            step();
            rd_check(1'b0, 16'h0010 << i, "R3");
        end
        periph = 6'b100101;
        step();
        rd_check(1'b0, 16'h0250, "R3");
        periph = '0;
        steps(4);

        // R9: status read while output low leaves it low
        want(cyc, 1'b0, 16'h0000, "R9");
        rd_check(1'b0, 16'h0000, "R9");
        want(cyc, 1'b0, 16'h0000, "R9");
        want(cyc + 1, 1'b0, 16'h0000, "R9");
        steps(2);

        // R6: masked peripheral request
        wr_en_reg(16'h83E0);
        periph = 6'b000001;
        c = cyc;
        want(c + 2, 1'b0, 16'h0000, "R6");
        want(c + 3, 1'b0, 16'h0000, "R6");
        steps(4);

        // R5: enabled peripheral request
        periph = 6'b000010;
        c = cyc;
        want(c + 1, 1'b0, 16'h0000, "R5");
        want(c + 2, 1'b0, 16'h0001, "R5");
        steps(3);
        periph = '0;
        steps(3);

        drain();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule